// File: doc/BRIEF.md
# Transmit Frame-Start Sequencer

This block is the control state machine of an Ethernet MAC transmit path. It decides when a frame may begin and then walks the frame through its phases: preamble, payload or pause-frame transmission, end of frame and interframe gap. While the payload phase lasts it strobes the transmit FIFO. It also defers to a busy medium in half duplex and holds off transmission for a received pause interval. The byte-level preamble, payload serialisation and CRC are done elsewhere, so here each phase is a fixed number of cycles.

A frame starts from idle only when the FIFO reports that it is not empty as well as ready. The ready flag from the FIFO is registered and stays high for one cycle after the last word of a frame has left. Gating the start on the empty flag keeps that late flag from starting a frame that has no data, which would cause a read from an empty FIFO.

Top module: `mac_tx_sequencer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `state_o` reads 0 (idle) and `fifo_rd` is low.
- R2: From idle, half duplex (`full_duplex`=0) with `crs`=1 moves to defer (code 1) ahead of any other choice. Defer holds while carrier stays up in half duplex, then returns to idle.
- R3: From idle, when defer does not apply, `pause_apply`=1 moves to pause (code 2) ahead of a frame start. Pause lasts `pause_quanta`+1 cycles, with the value taken on entry, then returns to idle.
- R4: From idle, a payload frame starts (preamble, code 3) only when `fifo_empty`=0 and `fifo_ra`=1, with either full duplex or no carrier. With `fifo_empty`=1 the machine stays idle even if `fifo_ra`=1.
- R5: With `pf_send_en`=1, a `xoff_req` or `xon_req` also starts a frame from idle, provided `fifo_empty`=0. That frame takes the pause-frame state (code 5) after the preamble instead of the data state. It keeps this choice if the request drops, lasts PF_CYC cycles, and then goes to end-of-frame.
- R6: Preamble lasts exactly PRE_CYC cycles and is followed by data (code 4) for a payload frame.
- R7: `fifo_rd` is high in every data-state cycle and in no other state. The cycle in which `fifo_eop`=1 is the last data cycle.
- R8: After data or pause frame, end-of-frame (code 6) lasts one cycle. It is followed by the interframe gap (code 7) for exactly IFG_CYC cycles, then idle. No FIFO read occurs in any of these, even if `fifo_ra` stays high.
- R9: With `pf_send_en`=0, `xoff_req` and `xon_req` have no effect on the idle decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| full_duplex | input | 1 | 1 = full duplex, 0 = half duplex |
| crs | input | 1 | Carrier sense |
| pause_apply | input | 1 | Request to hold off transmission |
| pause_quanta | input | QW | Hold-off length, taken when entering pause |
| fifo_ra | input | 1 | FIFO read-available (registered, may lag) |
| fifo_empty | input | 1 | FIFO empty |
| fifo_eop | input | 1 | Word at the FIFO head ends the packet |
| pf_send_en | input | 1 | Enables pause-frame transmission |
| xoff_req | input | 1 | Request to send an XOFF pause frame |
| xon_req | input | 1 | Request to send an XON pause frame |
| fifo_rd | output | 1 | FIFO read strobe |
| state_o | output | 4 | Current state code |

## Verification
The bench uses PRE_CYC=8 and IFG_CYC=12, the same as the defaults. It sets PF_CYC=6 and QW=8, so the pause-frame phase and the pause hold fit into short cycle-exact windows. Every idle decision is covered in one pass through a table. Directed runs then count each phase cycle by cycle. They hold a stale read-available flag against an empty FIFO across the gap and back into idle, and check that a dropped pause-frame request does not change the path the frame takes.

// File: rtl/mac_txs_pkg.sv
// Package: state codes shared by the transmit sequencer and its bench-visible state port.
package mac_txs_pkg;
    typedef enum logic [3:0] {
        TXS_IDLE     = 4'd0,
        TXS_DEFER    = 4'd1,
        TXS_PAUSE    = 4'd2,
        TXS_PREAMBLE = 4'd3,
        TXS_DATA     = 4'd4,
        TXS_PFRAME   = 4'd5,
        TXS_EOF      = 4'd6,
        TXS_IFG      = 4'd7
    } txs_state_t;
endpackage

// File: rtl/txs_start_qual.sv
// Module: txs_start_qual
// Decodes the three exits from idle into mutually exclusive requests,
// in priority defer > pause > frame start. Assumes all inputs are
// synchronous to the sequencer clock. Purely combinational.
module txs_start_qual (
    input  logic full_duplex,
    input  logic crs,
    input  logic pause_apply,
    input  logic fifo_ra,
    input  logic fifo_empty,
    input  logic pf_send_en,
    input  logic xoff_req,
    input  logic xon_req,
    output logic go_defer,
    output logic go_pause,
    output logic go_start,
    output logic start_pframe
);
    logic pf_req;
    logic link_ok;

    // Priority decode of the idle exits; empty gates every frame start.
    always_comb begin
        pf_req       = pf_send_en && (xoff_req || xon_req);
        link_ok      = fifo_ra && (full_duplex || !crs);
        go_defer     = !full_duplex && crs;
        go_pause     = !go_defer && pause_apply;
        go_start     = !go_defer && !go_pause && !fifo_empty && (link_ok || pf_req);
        start_pframe = pf_req;
    end
endmodule

// File: rtl/txs_phase_timer.sv
// Module: txs_phase_timer
// Down counter shared by all timed phases. A load sets the count; it
// then falls by one per cycle and rests at zero. Assumes the caller
// loads it on every entry to a timed phase.
module txs_phase_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_q;

    // Count register: load wins, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (load)       cnt_q <= load_val;
        else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
    end

    // Phase end flag.
    always_comb expired = (cnt_q == '0);
endmodule

// File: rtl/mac_tx_sequencer.sv
// Module: mac_tx_sequencer
// Transmit control state machine: idle/defer/pause arbitration, preamble,
// payload read or pause-frame phase, end-of-frame and interframe gap.
// Assumes a show-ahead FIFO whose fifo_eop marks the word read in the
// same cycle as fifo_rd, and a fifo_ra that may lag by a cycle.
module mac_tx_sequencer
    import mac_txs_pkg::*;
#(
    parameter int PRE_CYC = 8,
    parameter int IFG_CYC = 12,
    parameter int PF_CYC  = 64,
    parameter int QW      = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          full_duplex,
    input  logic          crs,
    input  logic          pause_apply,
    input  logic [QW-1:0] pause_quanta,
    input  logic          fifo_ra,
    input  logic          fifo_empty,
    input  logic          fifo_eop,
    input  logic          pf_send_en,
    input  logic          xoff_req,
    input  logic          xon_req,
    output logic          fifo_rd,
    output logic [3:0]    state_o
);
    localparam int MAX_A = (PRE_CYC > IFG_CYC) ? PRE_CYC : IFG_CYC;
    localparam int MAX_F = (PF_CYC > MAX_A) ? PF_CYC : MAX_A;
    localparam int FIXW  = $clog2(MAX_F) + 1;
    localparam int CW    = (QW > FIXW) ? QW : FIXW;

    txs_state_t    state_q, state_d;
    logic          pf_sel_q;
    logic          go_defer, go_pause, go_start, start_pframe;
    logic          t_load, t_expired;
    logic [CW-1:0] t_val;

    txs_start_qual i_qual (
        .full_duplex (full_duplex),
        .crs         (crs),
        .pause_apply (pause_apply),
        .fifo_ra     (fifo_ra),
        .fifo_empty  (fifo_empty),
        .pf_send_en  (pf_send_en),
        .xoff_req    (xoff_req),
        .xon_req     (xon_req),
        .go_defer    (go_defer),
        .go_pause    (go_pause),
        .go_start    (go_start),
        .start_pframe(start_pframe)
    );

    txs_phase_timer #(.CW(CW)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (t_load),
        .load_val(t_val),
        .expired (t_expired)
    );

    // Next-state and timer-load decode.
    always_comb begin
        state_d = state_q;
        t_load  = 1'b0;
        t_val   = '0;
        case (state_q)
            TXS_IDLE: begin
                if (go_defer) begin
                    state_d = TXS_DEFER;
                end else if (go_pause) begin
                    state_d = TXS_PAUSE;
                    t_load  = 1'b1;
                    t_val   = CW'(pause_quanta);
                end else if (go_start) begin
                    state_d = TXS_PREAMBLE;
                    t_load  = 1'b1;
                    t_val   = CW'(PRE_CYC - 1);
                end
            end
            TXS_DEFER:    if (full_duplex || !crs) state_d = TXS_IDLE;
            TXS_PAUSE:    if (t_expired) state_d = TXS_IDLE;
            TXS_PREAMBLE: begin
                if (t_expired) begin
                    if (pf_sel_q) begin
                        state_d = TXS_PFRAME;
                        t_load  = 1'b1;
                        t_val   = CW'(PF_CYC - 1);
                    end else begin
                        state_d = TXS_DATA;
                    end
                end
            end
            TXS_DATA:     if (fifo_eop) state_d = TXS_EOF;
            TXS_PFRAME:   if (t_expired) state_d = TXS_EOF;
            TXS_EOF: begin
                state_d = TXS_IFG;
                t_load  = 1'b1;
                t_val   = CW'(IFG_CYC - 1);
            end
            TXS_IFG:      if (t_expired) state_d = TXS_IDLE;
            default:      state_d = TXS_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TXS_IDLE;
        else        state_q <= state_d;
    end

    // Remembers whether the frame being started is a pause frame.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 pf_sel_q <= 1'b0;
        else if (state_q == TXS_IDLE && go_start)   pf_sel_q <= start_pframe;
    end

    // Outputs: read strobe during payload, raw state code.
    always_comb begin
        fifo_rd = (state_q == TXS_DATA);
        state_o = state_q;
    end

    // R7
    eop_ends_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_rd && fifo_eop) |=> (state_q == TXS_EOF));
    // R2
    defer_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TXS_IDLE && !full_duplex && crs) |=> (state_q == TXS_DEFER));
    // R3
    pause_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TXS_IDLE && (full_duplex || !crs) && pause_apply) |=> (state_q == TXS_PAUSE));
    // R4
    start_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TXS_PREAMBLE && $past(state_q) == TXS_IDLE) |-> !$past(fifo_empty));
    // R8
    ifg_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TXS_IFG) |=> (state_q == TXS_IFG || state_q == TXS_IDLE));
endmodule

// File: tb/test_mac_tx_sequencer.sv
module test_mac_tx_sequencer;
    localparam int PRE = 8;
    localparam int IFG = 12;
    localparam int PF  = 6;
    localparam int QW  = 8;
    localparam int NV  = 13;

    // Vector: [11]fd [10]crs [9]pause_apply [8]ra [7]empty [6]pf_en [5]xoff [4]xon [3:0] expected state
    localparam logic [11:0] VEC [NV] = '{
        12'b0111_0000_0001, // R2 defer beats pause and start
        12'b1111_0000_0010, // R3 full duplex ignores crs, pause beats start
        12'b1001_0000_0011, // R4 full duplex start
        12'b1001_1000_0000, // R4 ra with empty: stay idle
        12'b0001_0000_0011, // R4 half duplex, no carrier
        12'b1101_0000_0011, // R4 full duplex ignores carrier
        12'b1000_0000_0000, // R4 nothing ready
        12'b1000_0110_0011, // R5 xoff start
        12'b1000_0101_0011, // R5 xon start
        12'b1000_0011_0000, // R9 requests without enable
        12'b1000_1110_0000, // R5 pause frame needs non-empty
        12'b0101_0110_0001, // R2 defer beats pause frame
        12'b0010_0000_0010  // R3 half duplex no carrier pause
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic full_duplex = 1'b0, crs = 1'b0, pause_apply = 1'b0;
    logic [QW-1:0] pause_quanta = '0;
    logic fifo_ra = 1'b0, fifo_empty = 1'b1, fifo_eop = 1'b0;
    logic pf_send_en = 1'b0, xoff_req = 1'b0, xon_req = 1'b0;
    logic fifo_rd;
    logic [3:0] state_o;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mac_tx_sequencer #(.PRE_CYC(PRE), .IFG_CYC(IFG), .PF_CYC(PF), .QW(QW)) i_mac_tx_sequencer (
        .clk(clk), .rst_n(rst_n), .full_duplex(full_duplex), .crs(crs),
        .pause_apply(pause_apply), .pause_quanta(pause_quanta),
        .fifo_ra(fifo_ra), .fifo_empty(fifo_empty), .fifo_eop(fifo_eop),
        .pf_send_en(pf_send_en), .xoff_req(xoff_req), .xon_req(xon_req),
        .fifo_rd(fifo_rd), .state_o(state_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // Checks state and read strobe together (read expected only in data).
    task automatic chk_st(input string req, input int exp);
        chk(req, int'(state_o), exp);
        chk(req, int'(fifo_rd), (exp == 4) ? 1 : 0);
    endtask

    task automatic clear_in();
        full_duplex = 0; crs = 0; pause_apply = 0; pause_quanta = '0;
        fifo_ra = 0; fifo_empty = 1; fifo_eop = 0;
        pf_send_en = 0; xoff_req = 0; xon_req = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        clear_in();
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        clear_in();
        repeat (2) @(negedge clk);
        chk_st("R1 in reset", 0);
        rst_n = 1;
        @(posedge clk);
        @(negedge clk);
        chk_st("R1 after release", 0);

        // Idle decision table.
        for (int v = 0; v < NV; v++) begin
            do_reset();
            full_duplex = VEC[v][11]; crs = VEC[v][10]; pause_apply = VEC[v][9];
            fifo_ra = VEC[v][8]; fifo_empty = VEC[v][7]; pf_send_en = VEC[v][6];
            xoff_req = VEC[v][5]; xon_req = VEC[v][4]; pause_quanta = 8'd3;
            @(posedge clk);
            @(negedge clk);
            chk_st($sformatf("R2/R3/R4/R5/R9 vector %0d", v), int'(VEC[v][3:0]));
        end

        // Full payload frame with a stale ready flag afterwards.
        do_reset();
        full_duplex = 1; fifo_ra = 1; fifo_empty = 0;
        @(posedge clk);
        for (int i = 0; i < PRE; i++) begin
            @(negedge clk); chk_st("R6 preamble", 3); @(posedge clk);
        end
        @(negedge clk); chk_st("R6 data after preamble", 4);
        @(posedge clk);
        @(negedge clk); chk_st("R7 data continues", 4);
        fifo_eop = 1;
        @(posedge clk);
        @(negedge clk); chk_st("R7 eop ends data", 6);
        fifo_eop = 0; fifo_empty = 1; fifo_ra = 1;
        @(posedge clk);
        for (int i = 0; i < IFG; i++) begin
            @(negedge clk); chk_st("R8 gap", 7); @(posedge clk);
        end
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); chk_st("R4 stale ra held idle", 0); @(posedge clk);
        end
        @(negedge clk); fifo_empty = 0;
        @(posedge clk);
        @(negedge clk); chk_st("R4 new packet starts", 3);

        // Pause hold of quanta+1 cycles, request dropped after entry.
        do_reset();
        full_duplex = 1; pause_apply = 1; pause_quanta = 8'd5;
        fifo_ra = 1; fifo_empty = 0;
        @(posedge clk);
        @(negedge clk); pause_apply = 0; pause_quanta = 8'd0;
        for (int i = 0; i < 6; i++) begin
            chk_st("R3 pause hold", 2); @(posedge clk); @(negedge clk);
        end
        chk_st("R3 pause end", 0);

        // Defer hold and release.
        do_reset();
        crs = 1; fifo_ra = 1; fifo_empty = 0;
        @(posedge clk);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); chk_st("R2 defer hold", 1); @(posedge clk);
        end
        @(negedge clk); crs = 0;
        @(posedge clk);
        @(negedge clk); chk_st("R2 defer release", 0);
        @(posedge clk);
        @(negedge clk); chk_st("R4 start after defer", 3);

        // Pause frame, request dropped after the start.
        do_reset();
        full_duplex = 1; pf_send_en = 1; xoff_req = 1; fifo_empty = 0;
        @(posedge clk);
        @(negedge clk); xoff_req = 0;
        for (int i = 0; i < PRE; i++) begin
            chk_st("R5 pause-frame preamble", 3); @(posedge clk); @(negedge clk);
        end
        for (int i = 0; i < PF; i++) begin
            chk_st("R5 pause-frame body", 5); @(posedge clk); @(negedge clk);
        end
        chk_st("R5 pause frame to eof", 6);

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule